// File: doc/BRIEF.md
# Gated Edge Counter

This block measures the frequency of a signal by counting its rising edges during a gate window. The gate comes from one of two places: an external gate pin, or a gate generator elsewhere on the chip that is already synchronous to the block clock. While the selected gate is low the count holds its value, so software can read a stable result between windows. The count keeps adding across windows until software issues a clear. A sticky flag records that the counter wrapped.

An interrupt pulse marks the end of each window, which is the gate falling edge. As an option it can also mark the start of each window, which is the gate rising edge. The measured input and the external gate are asynchronous. Each passes through a two-flop synchronizer, and edges are found by comparing the synchronized level with its value one clock earlier.

Top module: `gated_edge_counter`

## Requirements
- R1: While the selected gate is high, every rising edge of `meas_in` adds exactly one to `count`. The new value appears after the third rising clock edge that follows the change on `meas_in`.
- R2: While the selected gate is low, rising edges of `meas_in` leave `count` unchanged.
- R3: `gate_sel` = 2'b00 selects the synchronized `gate_ext` pin. Any other value of `gate_sel` selects `gate_int`, which is used as it arrives, without synchronization.
- R4: With `edge_both` = 0, `irq` pulses for one cycle after each falling edge of the selected gate, and never after a rising edge.
- R5: With `edge_both` = 1, `irq` pulses for one cycle after each rising edge and after each falling edge of the selected gate.
- R6: The count is not reset between gate windows. A new window continues from the value that was held.
- R7: A high `clear` in a cycle sets `count` to 0 and clears `ovf` on the next clock edge. If a counted edge arrives in the same cycle, the clear still wins.
- R8: When `count` wraps from all ones to zero, `ovf` is set. It stays set until a clear.
- R9: `gate_level` shows the current level of the selected gate. For the external pin this is the level after synchronization.
- R10: During and after reset, `count` is 0, `ovf` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_in | input | 1 | Asynchronous signal whose edges are counted |
| gate_ext | input | 1 | Asynchronous external gate pin |
| gate_int | input | 1 | Gate from the on-chip generator, synchronous to `clk` |
| gate_sel | input | 2 | Gate source select; 00 picks the external pin |
| edge_both | input | 1 | 0: interrupt on falling gate edge; 1: on both gate edges |
| clear | input | 1 | Clears the count and the overflow flag |
| count | output | CNT_W | Accumulated edge count |
| ovf | output | 1 | Sticky wrap flag |
| gate_level | output | 1 | Current level of the selected gate |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Four properties are checked on every cycle. The count stays still whenever the gate is low and no clear is present. The count never moves by more than one per cycle. A clear always leaves a zero count and a cleared flag. The flag stays set until it is cleared. Only the bench's directed scenarios can show the rest: the three-cycle latency, which gate source is selected, which gate edges raise the interrupt, that counting goes on across windows, that a clear wins over a coincident edge, and that the flag is set at the exact wrap.

// File: rtl/gated_edge_counter.sv
module gated_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_in,
  input  logic             gate_ext,
  input  logic             gate_int,
  input  logic [1:0]       gate_sel,
  input  logic             edge_both,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             gate_level,
  output logic             irq
);

  logic [1:0] meas_sy, ext_sy;
  logic       meas_d, gate_d;
  logic       gate_now, meas_rise, gate_rise, gate_fall;

  assign gate_now   = (gate_sel == 2'b00) ? ext_sy[1] : gate_int;
  assign meas_rise  = meas_sy[1] & ~meas_d;
  assign gate_rise  = gate_now & ~gate_d;
  assign gate_fall  = ~gate_now & gate_d;
  assign gate_level = gate_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_sy <= '0;
      ext_sy  <= '0;
      meas_d  <= 1'b0;
      gate_d  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      meas_sy <= {meas_sy[0], meas_in};
      ext_sy  <= {ext_sy[0], gate_ext};
      meas_d  <= meas_sy[1];
      gate_d  <= gate_now;
      irq     <= gate_fall | (edge_both & gate_rise);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (meas_rise && gate_now) begin
      count <= count + CNT_W'(1);
      if (&count) ovf <= 1'b1;
    end
  end

  a_r2_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !gate_level) |=> $stable(count));

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0 && !ovf));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clear) |=> ovf);

endmodule

// File: tb/gated_edge_counter_test.sv
module gated_edge_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic meas_in = 0, gate_ext = 0, gate_int = 0, edge_both = 0, clear = 0;
  logic [1:0] gate_sel = 2'b01;
  logic [W-1:0] count;
  logic ovf, gate_level, irq;
  int errors = 0, checks = 0;
  bit done = 0;

  gated_edge_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .meas_in(meas_in), .gate_ext(gate_ext),
    .gate_int(gate_int), .gate_sel(gate_sel), .edge_both(edge_both),
    .clear(clear), .count(count), .ovf(ovf), .gate_level(gate_level), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) meas_in = 1;
    repeat (3) @(negedge clk);
    meas_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1;
    @(negedge clk) clear = 0;
  endtask

  task automatic count_irq(input int n, output int k);
    k = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (irq) k++;
    end
  endtask

  task automatic t_reset();
    chk(count == 0, "R10 count", int'(count), 0);
    chk(!ovf, "R10 ovf", int'(ovf), 0);
    chk(!irq, "R10 irq", int'(irq), 0);
  endtask

  task automatic t_latency();
    @(negedge clk) gate_int = 1; gate_sel = 2'b01;
    do_clear();
    @(negedge clk) meas_in = 1;
    @(posedge clk); @(posedge clk); #1;
    chk(count == 0, "R1 before third edge", int'(count), 0);
    @(posedge clk); #1;
    chk(count == 1, "R1 after third edge", int'(count), 1);
    @(negedge clk) meas_in = 0;
    repeat (3) @(negedge clk);
    pulse(); pulse();
    chk(count == 3, "R1 three edges", int'(count), 3);
  endtask

  task automatic t_closed_and_resume();
    @(negedge clk) gate_int = 0;
    repeat (2) @(negedge clk);
    chk(gate_level == 0, "R9 internal low", int'(gate_level), 0);
    pulse(); pulse();
    chk(count == 3, "R2 gate low holds", int'(count), 3);
    @(negedge clk) gate_int = 1;
    pulse();
    chk(count == 4, "R6 resume from held", int'(count), 4);
  endtask

  task automatic t_ext_gate();
    @(negedge clk) gate_int = 0; gate_ext = 1; gate_sel = 2'b00;
    repeat (3) @(negedge clk);
    chk(gate_level == 1, "R9 ext synced high", int'(gate_level), 1);
    pulse();
    chk(count == 5, "R3 ext gate counts", int'(count), 5);
    @(negedge clk) gate_sel = 2'b10;
    repeat (2) @(negedge clk);
    pulse();
    chk(count == 5, "R3 sel 10 uses internal low", int'(count), 5);
    @(negedge clk) gate_ext = 0; gate_sel = 2'b11; gate_int = 1;
    repeat (3) @(negedge clk);
    pulse();
    chk(count == 6, "R3 sel 11 uses internal high", int'(count), 6);
  endtask

  task automatic t_irq_fall_only();
    int k;
    @(negedge clk) edge_both = 0; gate_sel = 2'b01; gate_int = 0;
    repeat (3) @(negedge clk);
    gate_int = 1;
    count_irq(4, k);
    chk(k == 0, "R4 no irq on rise", k, 0);
    @(negedge clk) gate_int = 0;
    @(posedge clk); #1;
    chk(irq == 1, "R4 irq after fall", int'(irq), 1);
    @(posedge clk); #1;
    chk(irq == 0, "R4 single cycle", int'(irq), 0);
  endtask

  task automatic t_irq_both();
    int k;
    @(negedge clk) edge_both = 1;
    repeat (2) @(negedge clk);
    gate_int = 1;
    count_irq(4, k);
    chk(k == 1, "R5 one pulse on rise", k, 1);
    @(negedge clk) gate_int = 0;
    count_irq(4, k);
    chk(k == 1, "R5 one pulse on fall", k, 1);
    @(negedge clk) edge_both = 0; gate_sel = 2'b00; gate_ext = 1;
    repeat (5) @(negedge clk);
    gate_ext = 0;
    count_irq(5, k);
    chk(k == 1, "R4 ext gate fall", k, 1);
  endtask

  task automatic t_clear_wins();
    @(negedge clk) gate_sel = 2'b01; gate_int = 1;
    repeat (3) @(negedge clk);
    meas_in = 1;
    @(negedge clk);
    @(negedge clk) clear = 1;
    @(negedge clk) clear = 0;
    chk(count == 0, "R7 clear beats edge", int'(count), 0);
    @(negedge clk) meas_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_overflow();
    do_clear();
    for (int i = 0; i < 255; i++) pulse();
    chk(count == 255, "R8 at all ones", int'(count), 255);
    chk(!ovf, "R8 no flag before wrap", int'(ovf), 0);
    pulse();
    chk(count == 0, "R8 wrapped", int'(count), 0);
    chk(ovf == 1, "R8 flag set", int'(ovf), 1);
    pulse();
    @(negedge clk) gate_int = 0;
    repeat (4) @(negedge clk);
    chk(ovf == 1, "R8 flag sticky", int'(ovf), 1);
    do_clear();
    chk(!ovf && count == 0, "R7 clear flag", int'(ovf), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_closed_and_resume();
    t_ext_gate();
    t_irq_fall_only();
    t_irq_both();
    t_clear_wins();
    t_overflow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule